// File: doc/BRIEF.md
# Buffer-Descriptor DMA Channel

This block is one DMA channel that works through a table of buffer descriptors kept in system memory. Each descriptor names a byte count, a source address and a destination address. The channel fetches a descriptor and moves the data it describes over a simple synchronous bus master port. It then marks the descriptor as consumed and steps to the next entry. It stops when it reaches an entry that is not marked valid. Data can move from memory to memory, from a peripheral to memory, or from memory to a peripheral. Peripheral beats are paced by a request/acknowledge handshake.

Software sets the channel up through a small register write port. A mode register selects the peripheral port width, the transfer direction, and whether each beat uses two bus transactions (read, then write) or one fly-by transaction. In a fly-by transaction the peripheral supplies or takes the data directly. A table base register gives the first descriptor. A command write starts the walk. Each descriptor is four 32-bit words in this order: status, byte count, source address, destination address. In the status word, bit 31 marks the entry valid and bit 30 marks it as the last entry in the table.

Top module: `desc_dma_chan`

## Requirements
- R1: Register 0 holds the mode. Bits [1:0] are the width code: 00 = 32-bit, 01 = 16-bit, 10 = 8-bit, 11 = reserved. Bits [3:2] are the direction code: 00 = memory to memory, 01 = peripheral to memory, 10 = memory to peripheral, 11 = reserved. Bit 4 selects fly-by operation. Bits [31:5] always read as zero. Reset clears the register to zero.
- R2: A write to register 1 while idle loads the table base and also loads the descriptor pointer, which reads back at register 2. Reset clears both to zero.
- R3: A command write (register 2) with a reserved width or direction code sets the error flag, starts no bus access and leaves the channel idle. The next command with legal codes clears the flag.
- R4: On starting a descriptor, the channel reads the words at pointer +0, +4, +8 and +12, in that order, as status, count, source and destination. It holds memReq, memAddr and memWe steady until memAck.
- R5: If the fetched status has bit 31 clear, the channel raises done for exactly one cycle and returns to idle. The descriptor pointer keeps addressing that entry.
- R6: When fly-by is not in effect, each beat reads at the source pointer and then writes the data it read to the destination pointer. Both pointers then advance, and the remaining count drops by the beat size.
- R7: The beat size is 4, 2 or 1 bytes for width codes 00, 01 and 10. memSize carries the width code on data beats and 00 on descriptor accesses.
- R8: With fly-by set and direction 01, each beat is a single write at the destination pointer with memWdata driven to zero, and only the destination pointer advances. With direction 10, each beat is a single read at the source pointer, and only the source pointer advances. With direction 00, the fly-by bit has no effect.
- R9: In directions 01 and 10, every beat waits for perReq high. perAck is high for one cycle per beat, in the cycle of that beat's final memAck.
- R10: After the last beat, the channel writes the status word back with bit 31 cleared. The pointer then moves to the table base if bit 30 was set, or to pointer +16 otherwise, and the next descriptor is fetched.
- R11: Writes to the mode, base and command registers while the channel is busy are ignored.
- R12: A descriptor ends once the remaining count is smaller than one beat. A zero count moves no data, and a remainder shorter than one beat is left untransferred.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Register write strobe |
| cfgAddr | input | 2 | Register select: 0 mode, 1 base, 2 command (write) / pointer (read) |
| cfgWdata | input | 32 | Register write data |
| cfgRdata | output | 32 | Register read data for cfgAddr |
| memReq | output | 1 | Bus request, held until memAck |
| memWe | output | 1 | Bus write enable |
| memSize | output | 2 | Bus access width code |
| memAddr | output | AW | Bus byte address |
| memWdata | output | 32 | Bus write data |
| memRdata | input | 32 | Bus read data, valid with memAck |
| memAck | input | 1 | Bus completion, one cycle |
| perReq | input | 1 | Peripheral ready for a beat |
| perAck | output | 1 | Peripheral beat acknowledge |
| busy | output | 1 | Channel is walking descriptors |
| done | output | 1 | One-cycle pulse on reaching an invalid descriptor |
| err | output | 1 | Reserved mode code seen at start |

## Verification
Register writes and data movement can coincide. The bench stalls a peripheral-paced beat by holding perReq low after the descriptor fetch. In that window it writes new mode and base values. It then releases the beat and lets the walk finish. The writes are judged as ignored if the read-back mode and base are unchanged after done, and if the access count, beat count and data match the original mode.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

  localparam int MODE_W = 5;

  localparam logic [1:0] WID_WORD = 2'b00;
  localparam logic [1:0] WID_HALF = 2'b01;
  localparam logic [1:0] WID_BYTE = 2'b10;
  localparam logic [1:0] WID_RSVD = 2'b11;

  localparam logic [1:0] DIR_M2M  = 2'b00;
  localparam logic [1:0] DIR_P2M  = 2'b01;
  localparam logic [1:0] DIR_M2P  = 2'b10;
  localparam logic [1:0] DIR_RSVD = 2'b11;

  localparam logic [1:0] CFG_MODE = 2'd0;
  localparam logic [1:0] CFG_BASE = 2'd1;
  localparam logic [1:0] CFG_CMD  = 2'd2;

  typedef enum logic [2:0] {
    SEL_DESC0, SEL_DESC1, SEL_DESC2, SEL_DESC3, SEL_SRC, SEL_DST
  } addrSel_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_F0, ST_F1, ST_F2, ST_F3, ST_CHK, ST_WAITP, ST_RD, ST_WR, ST_WB
  } chanState_e;

  typedef struct packed {
    logic     ptrFromBase;
    logic     ptrNext;
    logic     ldStat;
    logic     ldCnt;
    logic     ldSrc;
    logic     ldDst;
    logic     ldData;
    logic     advSrc;
    logic     advDst;
    logic     decCnt;
    addrSel_e addrSel;
  } dpStrobe_t;

endpackage

// File: rtl/dma_chan_dp.sv
module dma_chan_dp
  import dma_chan_pkg::*;
#(
  parameter int AW        = 32,
  parameter int CW        = 16,
  parameter int VALID_BIT = 31,
  parameter int WRAP_BIT  = 30
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cfgWe,
  input  logic [1:0]    cfgAddr,
  input  logic [31:0]   cfgWdata,
  input  logic          cfgOpen,
  output logic [31:0]   cfgRdata,
  input  dpStrobe_t     stb,
  input  logic [31:0]   memRdata,
  output logic [AW-1:0] memAddr,
  output logic [31:0]   memWdata,
  output logic [1:0]    memSize,
  output logic [1:0]    modeWidth,
  output logic [1:0]    modeDir,
  output logic          modeSingle,
  output logic          goReq,
  output logic          countShort,
  output logic          descValid,
  output logic          descWrap
);

  localparam int DW         = 32;
  localparam int WORD_BYTES = 4;
  localparam int DESC_WORDS = 4;
  localparam int DESC_BYTES = WORD_BYTES * DESC_WORDS;

  logic [MODE_W-1:0] modeR;
  logic [AW-1:0]     baseR;
  logic [AW-1:0]     ptrR;
  logic [AW-1:0]     srcR;
  logic [AW-1:0]     dstR;
  logic [CW-1:0]     cntR;
  logic [DW-1:0]     statR;
  logic [DW-1:0]     dataR;
  logic [3:0]        stepB;
  logic              flyWrite;
  logic [AW-1:0]     descAddr [DESC_WORDS];

  assign modeWidth  = modeR[1:0];
  assign modeDir    = modeR[3:2];
  assign modeSingle = modeR[4];

  always_comb begin
    unique case (modeWidth)
      WID_WORD: stepB = 4'd4;
      WID_HALF: stepB = 4'd2;
      WID_BYTE: stepB = 4'd1;
      default:  stepB = 4'd0;
    endcase
  end

  for (genvar gi = 0; gi < DESC_WORDS; gi++) begin : g_descAddr
    assign descAddr[gi] = ptrR + AW'(WORD_BYTES * gi);
  end

  assign goReq      = cfgWe && (cfgAddr == CFG_CMD);
  assign countShort = cntR < CW'(stepB);
  assign descValid  = memRdata[VALID_BIT];
  assign descWrap   = statR[WRAP_BIT];

  // configuration registers and descriptor pointer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeR <= '0;
      baseR <= '0;
      ptrR  <= '0;
    end else begin
      if (cfgWe && cfgOpen && cfgAddr == CFG_MODE) modeR <= cfgWdata[MODE_W-1:0];
      if (cfgWe && cfgOpen && cfgAddr == CFG_BASE) begin
        baseR <= cfgWdata[AW-1:0];
        ptrR  <= cfgWdata[AW-1:0];
      end else if (stb.ptrFromBase) begin
        ptrR <= baseR;
      end else if (stb.ptrNext) begin
        ptrR <= ptrR + AW'(DESC_BYTES);
      end
    end
  end

  // working copy of the current descriptor
  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcR  <= '0;
      dstR  <= '0;
      cntR  <= '0;
      statR <= '0;
      dataR <= '0;
    end else begin
      if (stb.ldStat) statR <= memRdata;
      if (stb.ldCnt) cntR <= memRdata[CW-1:0];
      else if (stb.decCnt) cntR <= cntR - CW'(stepB);
      if (stb.ldSrc) srcR <= memRdata[AW-1:0];
      else if (stb.advSrc) srcR <= srcR + AW'(stepB);
      if (stb.ldDst) dstR <= memRdata[AW-1:0];
      else if (stb.advDst) dstR <= dstR + AW'(stepB);
      if (stb.ldData) dataR <= memRdata;
    end
  end

  always_comb begin
    unique case (stb.addrSel)
      SEL_DESC0: memAddr = descAddr[0];
      SEL_DESC1: memAddr = descAddr[1];
      SEL_DESC2: memAddr = descAddr[2];
      SEL_DESC3: memAddr = descAddr[3];
      SEL_SRC:   memAddr = srcR;
      SEL_DST:   memAddr = dstR;
      default:   memAddr = descAddr[0];
    endcase
  end

  assign flyWrite = modeSingle && (modeDir == DIR_P2M) && (stb.addrSel == SEL_DST);
  assign memSize  = (stb.addrSel == SEL_SRC || stb.addrSel == SEL_DST) ? modeWidth : WID_WORD;

  always_comb begin
    if (stb.addrSel == SEL_DESC0) memWdata = statR & ~(DW'(1) << VALID_BIT);
    else if (flyWrite)            memWdata = '0;
    else                          memWdata = dataR;
  end

  always_comb begin
    unique case (cfgAddr)
      CFG_MODE: cfgRdata = {{(DW-MODE_W){1'b0}}, modeR};
      CFG_BASE: cfgRdata = DW'(baseR);
      CFG_CMD:  cfgRdata = DW'(ptrR);
      default:  cfgRdata = '0;
    endcase
  end

endmodule

// File: rtl/dma_chan_ctrl.sv
module dma_chan_ctrl
  import dma_chan_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] modeWidth,
  input  logic [1:0] modeDir,
  input  logic       modeSingle,
  input  logic       goReq,
  input  logic       countShort,
  input  logic       descValid,
  input  logic       descWrap,
  input  logic       memAck,
  input  logic       perReq,
  output dpStrobe_t  stb,
  output logic       cfgOpen,
  output logic       memReq,
  output logic       memWe,
  output logic       perAck,
  output logic       busy,
  output logic       done,
  output logic       err
);

  chanState_e state, nxt;
  logic illegal, perMode, flyBy;

  assign illegal = (modeWidth == WID_RSVD) || (modeDir == DIR_RSVD);
  assign perMode = (modeDir == DIR_P2M) || (modeDir == DIR_M2P);
  assign flyBy   = modeSingle && perMode;
  assign cfgOpen = (state == ST_IDLE);
  assign busy    = (state != ST_IDLE);

  always_comb begin
    nxt         = state;
    stb         = '0;
    stb.addrSel = SEL_DESC0;
    memReq      = 1'b0;
    memWe       = 1'b0;
    perAck      = 1'b0;
    done        = 1'b0;
    unique case (state)
      ST_IDLE: if (goReq && !illegal) nxt = ST_F0;
      ST_F0: begin
        memReq = 1'b1;
        if (memAck) begin
          stb.ldStat = 1'b1;
          if (descValid) nxt = ST_F1;
          else begin
            done = 1'b1;
            nxt  = ST_IDLE;
          end
        end
      end
      ST_F1: begin
        memReq = 1'b1;
        stb.addrSel = SEL_DESC1;
        if (memAck) begin
          stb.ldCnt = 1'b1;
          nxt = ST_F2;
        end
      end
      ST_F2: begin
        memReq = 1'b1;
        stb.addrSel = SEL_DESC2;
        if (memAck) begin
          stb.ldSrc = 1'b1;
          nxt = ST_F3;
        end
      end
      ST_F3: begin
        memReq = 1'b1;
        stb.addrSel = SEL_DESC3;
        if (memAck) begin
          stb.ldDst = 1'b1;
          nxt = ST_CHK;
        end
      end
      ST_CHK: begin
        if (countShort)   nxt = ST_WB;
        else if (perMode) nxt = ST_WAITP;
        else              nxt = ST_RD;
      end
      ST_WAITP: begin
        if (perReq) nxt = (flyBy && modeDir == DIR_P2M) ? ST_WR : ST_RD;
      end
      ST_RD: begin
        memReq = 1'b1;
        stb.addrSel = SEL_SRC;
        if (memAck) begin
          stb.ldData = 1'b1;
          stb.advSrc = 1'b1;
          if (flyBy) begin
            stb.decCnt = 1'b1;
            perAck = 1'b1;
            nxt = ST_CHK;
          end else begin
            nxt = ST_WR;
          end
        end
      end
      ST_WR: begin
        memReq = 1'b1;
        memWe  = 1'b1;
        stb.addrSel = SEL_DST;
        if (memAck) begin
          stb.advDst = 1'b1;
          stb.decCnt = 1'b1;
          perAck = perMode;
          nxt = ST_CHK;
        end
      end
      ST_WB: begin
        memReq = 1'b1;
        memWe  = 1'b1;
        if (memAck) begin
          if (descWrap) stb.ptrFromBase = 1'b1;
          else          stb.ptrNext = 1'b1;
          nxt = ST_F0;
        end
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      err   <= 1'b0;
    end else begin
      state <= nxt;
      if (state == ST_IDLE && goReq) err <= illegal;
    end
  end

endmodule

// File: rtl/desc_dma_chan.sv
module desc_dma_chan
  import dma_chan_pkg::*;
#(
  parameter int AW        = 32,
  parameter int CW        = 16,
  parameter int VALID_BIT = 31,
  parameter int WRAP_BIT  = 30
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cfgWe,
  input  logic [1:0]    cfgAddr,
  input  logic [31:0]   cfgWdata,
  output logic [31:0]   cfgRdata,
  output logic          memReq,
  output logic          memWe,
  output logic [1:0]    memSize,
  output logic [AW-1:0] memAddr,
  output logic [31:0]   memWdata,
  input  logic [31:0]   memRdata,
  input  logic          memAck,
  input  logic          perReq,
  output logic          perAck,
  output logic          busy,
  output logic          done,
  output logic          err
);

  dpStrobe_t  stb;
  logic       cfgOpen, goReq, countShort, descValid, descWrap, modeSingle;
  logic [1:0] modeWidth, modeDir;

  dma_chan_dp #(.AW(AW), .CW(CW), .VALID_BIT(VALID_BIT), .WRAP_BIT(WRAP_BIT)) u_dp (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgWdata(cfgWdata),
    .cfgOpen(cfgOpen), .cfgRdata(cfgRdata), .stb(stb), .memRdata(memRdata),
    .memAddr(memAddr), .memWdata(memWdata), .memSize(memSize),
    .modeWidth(modeWidth), .modeDir(modeDir), .modeSingle(modeSingle),
    .goReq(goReq), .countShort(countShort), .descValid(descValid), .descWrap(descWrap)
  );

  dma_chan_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .modeWidth(modeWidth), .modeDir(modeDir),
    .modeSingle(modeSingle), .goReq(goReq), .countShort(countShort),
    .descValid(descValid), .descWrap(descWrap), .memAck(memAck), .perReq(perReq),
    .stb(stb), .cfgOpen(cfgOpen), .memReq(memReq), .memWe(memWe), .perAck(perAck),
    .busy(busy), .done(done), .err(err)
  );

endmodule

// File: rtl/dma_chan_chk.sv
module dma_chan_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rstN,
  input logic          memReq,
  input logic          memWe,
  input logic          memAck,
  input logic [AW-1:0] memAddr,
  input logic [1:0]    memSize,
  input logic          perAck,
  input logic          busy,
  input logic          done,
  input logic          err
);

  // R4
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck |=> memReq && $stable(memAddr) && $stable(memWe));

  // R9
  per_ack_beat_chk: assert property (@(posedge clk) disable iff (!rstN)
    perAck |-> memReq && memAck);

  // R7
  beat_size_chk: assert property (@(posedge clk) disable iff (!rstN)
    perAck |-> memSize != 2'b11);

  // R5
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !busy && !done);

  // R3
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(err) |-> !busy && !memReq);

  // R5
  done_no_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !err);

endmodule

bind desc_dma_chan dma_chan_chk #(.AW(AW)) u_chk (
  .clk(clk), .rstN(rstN), .memReq(memReq), .memWe(memWe), .memAck(memAck),
  .memAddr(memAddr), .memSize(memSize), .perAck(perAck), .busy(busy),
  .done(done), .err(err)
);

// File: tb/sim_desc_dma_chan.sv
`timescale 1ns/1ps
module sim_desc_dma_chan;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWe = 1'b0;
  logic [1:0]  cfgAddr = 2'd0;
  logic [31:0] cfgWdata = '0;
  logic [31:0] cfgRdata;
  logic        memReq, memWe;
  logic [1:0]  memSize;
  logic [31:0] memAddr, memWdata;
  logic [31:0] memRdata = '0;
  logic        memAck = 1'b0;
  logic        perReq = 1'b1;
  logic        perAck, busy, done, err;

  always #10 clk = ~clk;

  desc_dma_chan u0 (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgWdata(cfgWdata),
    .cfgRdata(cfgRdata), .memReq(memReq), .memWe(memWe), .memSize(memSize),
    .memAddr(memAddr), .memWdata(memWdata), .memRdata(memRdata), .memAck(memAck),
    .perReq(perReq), .perAck(perAck), .busy(busy), .done(done), .err(err)
  );

  localparam logic [31:0] BASE = 32'h40;
  localparam logic [31:0] SRC  = 32'h200;
  localparam logic [31:0] DST  = 32'h300;

  // {fly-by, direction[1:0], width[1:0], count[15:0]}
  localparam logic [20:0] VECS [0:7] = '{
    {1'b0, 2'd0, 2'd0, 16'd8},  // word copy, R6
    {1'b0, 2'd1, 2'd1, 16'd6},  // half, peripheral to memory
    {1'b0, 2'd2, 2'd2, 16'd5},  // byte, memory to peripheral
    {1'b1, 2'd1, 2'd0, 16'd8},  // fly-by write, R8
    {1'b1, 2'd2, 2'd1, 16'd4},  // fly-by read, R8
    {1'b1, 2'd0, 2'd0, 16'd4},  // fly-by ignored for memory copy, R8
    {1'b0, 2'd0, 2'd2, 16'd0},  // zero count, R12
    {1'b0, 2'd0, 2'd0, 16'd6}   // remainder left, R12
  };

  logic [7:0]  mem [0:1023];
  int nChk = 0, nFail = 0;
  int logN = 0, perAckCnt = 0, doneCnt = 0, doneLong = 0;
  logic doneRun = 1'b0;
  logic [31:0] logA [0:63];
  logic        logW [0:63];
  logic [1:0]  logS [0:63];

  function automatic int ix(input logic [31:0] a, input int k);
    return (int'(a[9:0]) + k) % 1024;
  endfunction

  function automatic logic [31:0] rd32(input logic [31:0] a);
    return {mem[ix(a, 3)], mem[ix(a, 2)], mem[ix(a, 1)], mem[ix(a, 0)]};
  endfunction

  // bus slave: one-cycle ack after request, little-endian bytes
  always @(posedge clk) begin
    memAck <= memReq && !memAck;
    if (memReq && !memAck) begin
      memRdata <= rd32(memAddr);
      if (memWe) begin
        for (int k = 0; k < ((memSize == 2'd0) ? 4 : (memSize == 2'd1) ? 2 : 1); k++)
          mem[ix(memAddr, k)] = memWdata[8*k +: 8];
      end
    end
  end

  always @(posedge clk) begin
    if (rstN) begin
      if (memReq && memAck) begin
        if (logN < 64) begin
          logA[logN] = memAddr;
          logW[logN] = memWe;
          logS[logN] = memSize;
        end
        logN++;
      end
      if (perAck) perAckCnt++;
      if (done) begin
        doneCnt++;
        if (doneRun) doneLong++;
      end
      doneRun = done;
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChk++;
    nFail++;
    $display("FAIL watchdog: actual hung expected finished");
    summary();
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cfgWr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    cfgWe = 1'b1; cfgAddr = a; cfgWdata = d;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic cfgRd(input logic [1:0] a, output logic [31:0] d);
    cfgAddr = a;
    #1;
    d = cfgRdata;
  endtask

  task automatic put32(input logic [31:0] a, input logic [31:0] d);
    for (int k = 0; k < 4; k++) mem[ix(a, k)] = d[8*k +: 8];
  endtask

  task automatic setup(input logic [31:0] stat, input logic [31:0] cnt);
    for (int k = 0; k < 1024; k++) mem[k] = 8'h00;
    for (int k = 0; k < 16; k++) begin
      mem[ix(SRC, k)] = 8'hA0 + 8'(k);
      mem[ix(DST, k)] = 8'h55;
    end
    put32(BASE, stat);
    put32(BASE + 4, cnt);
    put32(BASE + 8, SRC);
    put32(BASE + 12, DST);
    put32(BASE + 16, 32'h0);
  endtask

  task automatic clearStats();
    logN = 0; perAckCnt = 0; doneLong = 0;
  endtask

  task automatic waitDone(input string req);
    int start, t;
    start = doneCnt;
    t = 0;
    while (doneCnt == start && t < 3000) begin
      @(negedge clk);
      t++;
    end
    chk(req, (doneCnt != start) ? 32'd1 : 32'd0, 32'd1);
  endtask

  initial begin
    logic [31:0] rv;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // reset state, R1 R2
    cfgRd(2'd0, rv); chk("R1 mode reset", rv, 32'h0);
    cfgRd(2'd1, rv); chk("R2 base reset", rv, 32'h0);
    cfgRd(2'd2, rv); chk("R2 pointer reset", rv, 32'h0);
    chk("R5 idle outputs after reset", {busy, done, err, memReq}, 32'h0);
    cfgWr(2'd0, 32'hFFFF_FFFF);
    cfgRd(2'd0, rv); chk("R1 reserved bits read zero", rv, 32'h1F);

    // vector table
    for (int v = 0; v < 8; v++) begin
      logic fly, perMode, single;
      logic [1:0] dir, wid;
      int cnt, step, beats, nBad;
      string tag;
      fly = VECS[v][20]; dir = VECS[v][19:18]; wid = VECS[v][17:16]; cnt = int'(VECS[v][15:0]);
      step = (wid == 2'd0) ? 4 : (wid == 2'd1) ? 2 : 1;
      beats = cnt / step;
      perMode = (dir != 2'd0);
      single = fly && perMode;
      tag = ((cnt % step) != 0 || cnt == 0) ? "R12" : (single ? "R8" : "R6");
      setup(32'h8000_0000, 32'(cnt));
      cfgWr(2'd0, {27'd0, fly, dir, wid});
      cfgWr(2'd1, BASE);
      clearStats();
      cfgWr(2'd2, 32'h0);
      waitDone($sformatf("R5 vector %0d done", v));
      chk($sformatf("%s vector %0d bus accesses", tag, v), 32'(logN), 32'(6 + beats * (single ? 1 : 2)));
      chk($sformatf("R9 vector %0d perAck beats", v), 32'(perAckCnt), perMode ? 32'(beats) : 32'd0);
      nBad = 0;
      for (int i = 0; i < 16; i++) begin
        logic [7:0] e;
        if (i < beats * step) e = single ? ((dir == 2'd1) ? 8'h00 : 8'h55) : 8'hA0 + 8'(i);
        else e = 8'h55;
        if (mem[ix(DST, i)] !== e) nBad++;
      end
      chk($sformatf("%s vector %0d destination bytes", tag, v), 32'(nBad), 32'd0);
      chk($sformatf("R10 vector %0d status cleared", v), rd32(BASE), 32'h0);
      cfgRd(2'd2, rv); chk($sformatf("R10 vector %0d pointer stepped", v), rv, BASE + 16);
      chk($sformatf("R5 vector %0d done width", v), 32'(doneLong), 32'd0);
      if (v == 0) begin
        chk("R4 fetch order", {logA[0][7:0], logA[1][7:0], logA[2][7:0], logA[3][7:0]}, 32'h4044484C);
        chk("R6 first read at source", {logA[4], 31'd0, logW[4]}, {SRC, 32'd0});
        chk("R6 first write at destination", {logA[5], 31'd0, logW[5]}, {DST, 32'd1});
        chk("R6 source advanced by word", logA[6], SRC + 4);
      end
      if (v == 1) begin
        chk("R7 half beat size", 32'(logS[4]), 32'd1);
        chk("R7 descriptor size", 32'(logS[0]), 32'd0);
        chk("R7 source advanced by half", logA[6], SRC + 2);
      end
      if (v == 3) chk("R8 fly-by single write at destination", {logA[4], 31'd0, logW[4]}, {DST, 32'd1});
      if (v == 4) chk("R8 fly-by read advances source only", logA[5], SRC + 2);
    end

    // R3: reserved codes
    cfgWr(2'd0, 32'h03);
    clearStats();
    cfgWr(2'd2, 32'h0);
    repeat (10) @(negedge clk);
    chk("R3 reserved width sets err", {31'd0, err}, 32'd1);
    chk("R3 no bus access", 32'(logN), 32'd0);
    cfgWr(2'd0, 32'h0C);
    cfgWr(2'd2, 32'h0);
    repeat (4) @(negedge clk);
    chk("R3 reserved direction keeps err", {30'd0, err, busy}, 32'd2);

    // R5: invalid first descriptor clears err
    setup(32'h0, 32'd4);
    cfgWr(2'd0, 32'h0);
    cfgWr(2'd1, BASE);
    clearStats();
    cfgWr(2'd2, 32'h0);
    waitDone("R5 invalid descriptor done");
    chk("R3 legal start clears err", {31'd0, err}, 32'd0);
    chk("R5 only status read", 32'(logN), 32'd1);
    cfgRd(2'd2, rv); chk("R5 pointer unchanged", rv, BASE);
    chk("R5 done one cycle", 32'(doneLong), 32'd0);

    // R10: wrap bit returns pointer to base
    setup(32'hC000_0000, 32'd4);
    cfgWr(2'd1, BASE);
    clearStats();
    cfgWr(2'd2, 32'h0);
    waitDone("R10 wrap done");
    chk("R10 wrap accesses", 32'(logN), 32'd8);
    chk("R10 wrap refetch at base", logA[7], BASE);
    cfgRd(2'd2, rv); chk("R10 pointer at base", rv, BASE);
    chk("R10 wrap bit kept", rd32(BASE), 32'h4000_0000);

    // R9 and R11: stalled peripheral beat with writes during busy
    setup(32'h8000_0000, 32'd4);
    cfgWr(2'd0, 32'h04);
    cfgWr(2'd1, BASE);
    perReq = 1'b0;
    clearStats();
    cfgWr(2'd2, 32'h0);
    repeat (40) @(negedge clk);
    chk("R9 beat waits for perReq", {perAckCnt[30:0], busy}, 32'd1);
    chk("R9 only descriptor fetched", 32'(logN), 32'd4);
    cfgWr(2'd0, 32'h02);
    cfgWr(2'd1, 32'h80);
    cfgWr(2'd2, 32'h0);
    perReq = 1'b1;
    waitDone("R9 stalled beat completes");
    chk("R9 one perAck", 32'(perAckCnt), 32'd1);
    chk("R11 busy writes ignored accesses", 32'(logN), 32'd8);
    cfgRd(2'd0, rv); chk("R11 mode unchanged", rv, 32'h04);
    cfgRd(2'd1, rv); chk("R11 base unchanged", rv, BASE);
    chk("R11 data still moved", rd32(DST), 32'hA3A2A1A0);

    summary();
  end

endmodule